// File: doc/BRIEF.md
# Exception entry and return controller

This block owns the program status word and the saved-state registers of a small processor core, and decides where execution resumes whenever control flow is diverted by an exception. It accepts a maskable interrupt request carrying a 4-bit level, software trap requests carrying a 5-bit vector, a return-from-exception command, and the commands that enable or disable interrupts. Fetch and decode stay outside. The core supplies the resume address of the current instruction on `resume_pc`. The block answers with a one-cycle redirect strobe and a target address.

On an accepted interrupt the block saves state and builds the handler address from the level. It raises the interrupt mask to one above the accepted level and releases the core from halt. Traps and returns are multi-cycle operations: state updates at once, and the redirect appears after a fixed cost. While one of them is in progress, every further request is dropped. A trap raised while an exception is already being handled is a nested fault. That fault saves into the second, fatal register pair and marks the status word so that the next return restores from that pair.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000_1000 (interrupts disabled, mask level 0), the four saved-state outputs and the cause output read 0, and neither `redirect_valid` nor `halt_release` is high.
- R2: Status bit positions are disable 12, address-trap enable 13, exception-pending 14, fatal-pending 15, and the mask level in bits 19:16. An interrupt is accepted only when bits 12, 14 and 15 are all clear, the request level is at least the mask level, no command arrives in the same cycle and no operation is in progress. Otherwise the request leaves every output unchanged.
- R3: On acceptance `eipc_o` takes `resume_pc` and `eipsw_o` takes the status word held before the request.
- R4: On acceptance, in the cycle after the request is sampled, `redirect_valid` and `halt_release` both pulse for one cycle. `redirect_pc` is 0xFFFF_FE00 OR (level << 4), and `ecr_o` becomes 0x0000_FE00 OR (level << 4).
- R5: Acceptance sets bits 14 and 12, clears bit 13, writes min(level+1, 15) into bits 19:16, and keeps all other bits.
- R6: A trap with bits 14 and 15 both clear saves `resume_pc` and the status word into the normal pair, sets bits 14 and 12, and sets `ecr_o` to 0xFFA0 + vector. Counting the sampling cycle as the first, `redirect_valid` pulses in the 15th cycle with target 0xFFFF_FFA0 + (vector bit 4 × 16). `halt_release` stays low.
- R7: A return restores from the fatal pair if bit 15 is set, and from the normal pair otherwise. The status word is replaced by the saved one. The target is the saved PC with bit 0 cleared, and the redirect pulses in the 10th cycle counting the sampling cycle.
- R8: The disable command sets bit 12 and the enable command clears it. Either takes effect one cycle after sampling and produces no redirect.
- R9: Of requests arriving together, one is served, in the order trap, return, disable, enable, interrupt.
- R10: While a trap or return is in progress, all requests are ignored and the status word does not change.
- R11: A trap taken while bit 14 or bit 15 is set saves into the fatal pair (`fepc_o`, `fepsw_o`) and sets bits 15 and 12. The normal pair is left intact. Cause and target are as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Interrupt request present |
| irq_level | input | 4 | Level of the interrupt request |
| resume_pc | input | 32 | Address to save as the return point |
| trap_req | input | 1 | Software trap request |
| trap_vec | input | 5 | Trap vector number |
| reti_req | input | 1 | Return-from-exception command |
| ei_req | input | 1 | Enable-interrupts command |
| di_req | input | 1 | Disable-interrupts command |
| redirect_valid | output | 1 | One-cycle strobe: fetch from redirect_pc |
| redirect_pc | output | 32 | New fetch address |
| psw_o | output | 32 | Current status word |
| eipc_o | output | 32 | Saved PC, normal pair |
| eipsw_o | output | 32 | Saved status word, normal pair |
| fepc_o | output | 32 | Saved PC, fatal pair |
| fepsw_o | output | 32 | Saved status word, fatal pair |
| ecr_o | output | 32 | Exception cause code |
| halt_release | output | 1 | Pulse that wakes a halted core on interrupt acceptance |

## Verification
A wrong internal status word shows first at interrupt gating. An interrupt is then taken or refused in the wrong cycle, so a redirect appears one cycle after a request that should have been masked, or fails to appear where it was expected. A stale or wrong busy count shows as a redirect strobe in the wrong cycle of a 10- or 15-cycle window. It also shows as a request injected mid-window that changes the status word. Errors in the saved pairs stay hidden until the matching return, which then redirects to the wrong address. For that reason the stimulus nests an interrupt, a trap and two returns, and draws random request mixes whose outcome depends on the accumulated state.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN          = 32;
    localparam int LVL_W         = 4;
    localparam int VEC_W         = 5;
    localparam int RETURN_CYCLES = 10;
    localparam int TRAP_CYCLES   = 15;
    localparam int MAX_CYCLES    = (TRAP_CYCLES > RETURN_CYCLES) ? TRAP_CYCLES : RETURN_CYCLES;
    localparam int CNT_W         = $clog2(MAX_CYCLES + 1);

    localparam int BIT_ID = 12;
    localparam int BIT_AE = 13;
    localparam int BIT_EP = 14;
    localparam int BIT_NP = 15;
    localparam int IA_LO  = 16;

    localparam logic [XLEN-1:0] PSW_RESET      = 32'h0000_1000;
    localparam logic [XLEN-1:0] IRQ_PC_BASE    = 32'hFFFF_FE00;
    localparam logic [XLEN-1:0] IRQ_CODE_BASE  = 32'h0000_FE00;
    localparam logic [XLEN-1:0] TRAP_PC_BASE   = 32'hFFFF_FFA0;
    localparam logic [XLEN-1:0] TRAP_CODE_BASE = 32'h0000_FFA0;

    typedef struct packed {
        logic [XLEN-1:0]  psw;
        logic [XLEN-1:0]  eipc;
        logic [XLEN-1:0]  eipsw;
        logic [XLEN-1:0]  fepc;
        logic [XLEN-1:0]  fepsw;
        logic [XLEN-1:0]  ecr;
        logic [XLEN-1:0]  tgt;
        logic             redir;
        logic             wake;
        logic [CNT_W-1:0] cnt;
    } exc_state_t;
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
    import exc_pkg::*;
(
    input  logic [XLEN-1:0]  psw,
    input  logic             req,
    input  logic [LVL_W-1:0] level,
    output logic             take,
    output logic [LVL_W-1:0] next_mask
);
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    logic masked;

    always_comb begin
        masked    = psw[BIT_ID] | psw[BIT_EP] | psw[BIT_NP];
        take      = req && !masked && (level >= psw[IA_LO +: LVL_W]);
        next_mask = (level == LVL_MAX) ? LVL_MAX : level + 1'b1;
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_pkg::*;
(
    input  logic [LVL_W-1:0] level,
    input  logic [VEC_W-1:0] vec,
    output logic [XLEN-1:0]  irq_pc,
    output logic [XLEN-1:0]  irq_code,
    output logic [XLEN-1:0]  trap_pc,
    output logic [XLEN-1:0]  trap_code
);
    logic [XLEN-1:0] lvl_off;
    logic [XLEN-1:0] trap_off;

    always_comb begin
        lvl_off   = {{(XLEN-LVL_W-4){1'b0}}, level, 4'b0000};
        trap_off  = {{(XLEN-5){1'b0}}, vec[VEC_W-1], 4'b0000};
        irq_pc    = IRQ_PC_BASE   | lvl_off;
        irq_code  = IRQ_CODE_BASE | lvl_off;
        trap_pc   = TRAP_PC_BASE  + trap_off;
        trap_code = TRAP_CODE_BASE + {{(XLEN-VEC_W){1'b0}}, vec};
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_valid,
    input  logic [3:0]       irq_level,
    input  logic [31:0]      resume_pc,
    input  logic             trap_req,
    input  logic [4:0]       trap_vec,
    input  logic             reti_req,
    input  logic             ei_req,
    input  logic             di_req,
    output logic             redirect_valid,
    output logic [31:0]      redirect_pc,
    output logic [31:0]      psw_o,
    output logic [31:0]      eipc_o,
    output logic [31:0]      eipsw_o,
    output logic [31:0]      fepc_o,
    output logic [31:0]      fepsw_o,
    output logic [31:0]      ecr_o,
    output logic             halt_release
);
    localparam logic [CNT_W-1:0] TRAP_WAIT   = CNT_W'(TRAP_CYCLES - 1);
    localparam logic [CNT_W-1:0] RETURN_WAIT = CNT_W'(RETURN_CYCLES - 1);

    exc_state_t state_d, state_q;

    logic             irq_take;
    logic [LVL_W-1:0] irq_mask;
    logic [XLEN-1:0]  irq_pc, irq_code, trap_pc, trap_code;
    logic             busy;
    logic             nested;

    exc_irq_gate u_gate (
        .psw       (state_q.psw),
        .req       (irq_valid),
        .level     (irq_level),
        .take      (irq_take),
        .next_mask (irq_mask)
    );

    exc_vector_gen u_vec (
        .level     (irq_level),
        .vec       (trap_vec),
        .irq_pc    (irq_pc),
        .irq_code  (irq_code),
        .trap_pc   (trap_pc),
        .trap_code (trap_code)
    );

    always_comb begin
        state_d       = state_q;
        state_d.redir = 1'b0;
        state_d.wake  = 1'b0;
        busy          = (state_q.cnt != '0);
        nested        = state_q.psw[BIT_EP] | state_q.psw[BIT_NP];

        if (busy) begin
            state_d.cnt = state_q.cnt - 1'b1;
            if (state_q.cnt == CNT_W'(1)) begin
                state_d.redir = 1'b1;
            end
        end else if (trap_req) begin
            if (nested) begin
                state_d.fepc           = resume_pc;
                state_d.fepsw          = state_q.psw;
                state_d.psw[BIT_NP]    = 1'b1;
            end else begin
                state_d.eipc           = resume_pc;
                state_d.eipsw          = state_q.psw;
                state_d.psw[BIT_EP]    = 1'b1;
            end
            state_d.psw[BIT_ID] = 1'b1;
            state_d.ecr         = trap_code;
            state_d.tgt         = trap_pc;
            state_d.cnt         = TRAP_WAIT;
        end else if (reti_req) begin
            if (state_q.psw[BIT_NP]) begin
                state_d.tgt = {state_q.fepc[XLEN-1:1], 1'b0};
                state_d.psw = state_q.fepsw;
            end else begin
                state_d.tgt = {state_q.eipc[XLEN-1:1], 1'b0};
                state_d.psw = state_q.eipsw;
            end
            state_d.cnt = RETURN_WAIT;
        end else if (di_req) begin
            state_d.psw[BIT_ID] = 1'b1;
        end else if (ei_req) begin
            state_d.psw[BIT_ID] = 1'b0;
        end else if (irq_take) begin
            state_d.eipc                  = resume_pc;
            state_d.eipsw                 = state_q.psw;
            state_d.psw[BIT_EP]           = 1'b1;
            state_d.psw[BIT_ID]           = 1'b1;
            state_d.psw[BIT_AE]           = 1'b0;
            state_d.psw[IA_LO +: LVL_W]   = irq_mask;
            state_d.ecr                   = irq_code;
            state_d.tgt                   = irq_pc;
            state_d.redir                 = 1'b1;
            state_d.wake                  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.psw   <= PSW_RESET;
        end else begin
            state_q       <= state_d;
        end
    end

    assign redirect_valid = state_q.redir;
    assign redirect_pc    = state_q.tgt;
    assign psw_o          = state_q.psw;
    assign eipc_o         = state_q.eipc;
    assign eipsw_o        = state_q.eipsw;
    assign fepc_o         = state_q.fepc;
    assign fepsw_o        = state_q.fepsw;
    assign ecr_o          = state_q.ecr;
    assign halt_release   = state_q.wake;

    a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cnt != '0) |=> $stable(psw_o))
        else $error("status word changed during a busy window");

    a_r4_wake_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        halt_release |-> (redirect_valid && redirect_pc[31:9] == '1))
        else $error("halt release without interrupt redirect");

    a_r5_accept_flags: assert property (@(posedge clk) disable iff (!rst_n)
        halt_release |-> (psw_o[BIT_EP] && psw_o[BIT_ID] && !psw_o[BIT_AE]
                          && psw_o[IA_LO +: LVL_W] != '0))
        else $error("status word flags wrong after acceptance");

    a_r7_even_target: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !redirect_pc[0])
        else $error("odd redirect target");

    a_r2_masked_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cnt == '0 && irq_valid && psw_o[BIT_ID]) |=> !halt_release)
        else $error("interrupt taken while disabled");

    a_r8_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cnt == '0 && di_req && !trap_req && !reti_req) |=> psw_o[BIT_ID])
        else $error("disable command did not set the disable bit");
endmodule

// File: tb/exc_ctrl_tb.sv
`timescale 1ns/1ps
module exc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_valid, trap_req, reti_req, ei_req, di_req;
    logic [3:0]  irq_level;
    logic [4:0]  trap_vec;
    logic [31:0] resume_pc;
    logic        redirect_valid, halt_release;
    logic [31:0] redirect_pc, psw_o, eipc_o, eipsw_o, fepc_o, fepsw_o, ecr_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_psw, m_eipc, m_eipsw, m_fepc, m_fepsw, m_ecr;

    always #2.5 clk = ~clk;

    exc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_level(irq_level),
        .resume_pc(resume_pc), .trap_req(trap_req), .trap_vec(trap_vec),
        .reti_req(reti_req), .ei_req(ei_req), .di_req(di_req),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .psw_o(psw_o),
        .eipc_o(eipc_o), .eipsw_o(eipsw_o), .fepc_o(fepc_o), .fepsw_o(fepsw_o),
        .ecr_o(ecr_o), .halt_release(halt_release)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_accept(input logic [31:0] psw, input logic [3:0] lvl);
        return !psw[12] && !psw[14] && !psw[15] && (lvl >= psw[19:16]);
    endfunction

    function automatic logic [3:0] m_mask(input logic [3:0] lvl);
        return (lvl == 4'hF) ? 4'hF : lvl + 4'd1;
    endfunction

    task automatic clear_inputs();
        irq_valid = 0; trap_req = 0; reti_req = 0; ei_req = 0; di_req = 0;
    endtask

    task automatic check_state(input string tag);
        chk(psw_o == m_psw,     {tag, " psw"},   psw_o,   m_psw);
        chk(eipc_o == m_eipc,   {tag, " eipc"},  eipc_o,  m_eipc);
        chk(eipsw_o == m_eipsw, {tag, " eipsw"}, eipsw_o, m_eipsw);
        chk(fepc_o == m_fepc,   {tag, " fepc"},  fepc_o,  m_fepc);
        chk(fepsw_o == m_fepsw, {tag, " fepsw"}, fepsw_o, m_fepsw);
        chk(ecr_o == m_ecr,     {tag, " ecr"},   ecr_o,   m_ecr);
    endtask

    // One request cycle, then wait out its cost; optional injection mid-window (R10).
    task automatic step(input bit t, input bit r, input bit d, input bit e, input bit iv,
                        input logic [3:0] lvl, input logic [4:0] vec, input logic [31:0] pc,
                        input bit inject, input string tag);
        int lat;
        logic [31:0] epc;
        bit ewake;
        lat = 0; epc = '0; ewake = 0;
        if (t) begin
            if (m_psw[14] || m_psw[15]) begin
                m_fepc = pc; m_fepsw = m_psw; m_psw[15] = 1'b1;      // R11
            end else begin
                m_eipc = pc; m_eipsw = m_psw; m_psw[14] = 1'b1;      // R6
            end
            m_psw[12] = 1'b1;
            m_ecr = 32'h0000_FFA0 + {27'd0, vec};
            epc = 32'hFFFF_FFA0 + (vec[4] ? 32'd16 : 32'd0);
            lat = 15;
        end else if (r) begin                                        // R7
            if (m_psw[15]) begin
                epc = {m_fepc[31:1], 1'b0}; m_psw = m_fepsw;
            end else begin
                epc = {m_eipc[31:1], 1'b0}; m_psw = m_eipsw;
            end
            lat = 10;
        end else if (d) begin
            m_psw[12] = 1'b1;                                        // R8
        end else if (e) begin
            m_psw[12] = 1'b0;
        end else if (iv && m_accept(m_psw, lvl)) begin              // R3 R4 R5
            m_eipc = pc; m_eipsw = m_psw;
            m_psw[14] = 1'b1; m_psw[12] = 1'b1; m_psw[13] = 1'b0;
            m_psw[19:16] = m_mask(lvl);
            m_ecr = 32'h0000_FE00 | {24'd0, lvl, 4'd0};
            epc = 32'hFFFF_FE00 | {24'd0, lvl, 4'd0};
            lat = 1; ewake = 1;
        end
        @(negedge clk);
        trap_req = t; reti_req = r; di_req = d; ei_req = e; irq_valid = iv;
        irq_level = lvl; trap_vec = vec; resume_pc = pc;
        @(posedge clk);
        #1 clear_inputs();
        if (lat == 0) begin
            @(negedge clk);
            chk(redirect_valid == 1'b0, {tag, " no redirect"}, {31'd0, redirect_valid}, 32'd0);
        end else begin
            for (int k = 1; k <= lat; k++) begin
                @(negedge clk);
                if (k < lat) begin
                    if (redirect_valid) chk(1'b0, {tag, " early redirect"}, k, lat);
                    if (inject && k == 2) begin
                        trap_req = 1; di_req = 1; ei_req = 1; reti_req = 1; irq_valid = 1;
                        irq_level = 4'hF; trap_vec = 5'h1F;
                        @(posedge clk);
                        #1 clear_inputs();
                    end
                end else begin
                    chk(redirect_valid == 1'b1, {tag, " redirect strobe"}, {31'd0, redirect_valid}, 32'd1);
                    chk(redirect_pc == epc, {tag, " target"}, redirect_pc, epc);
                    chk(halt_release == ewake, {tag, " halt release"}, {31'd0, halt_release}, {31'd0, ewake});
                end
            end
        end
        check_state(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clear_inputs();
        irq_level = '0; trap_vec = '0; resume_pc = '0;
        rst_n = 0;
        m_psw = 32'h0000_1000; m_eipc = 0; m_eipsw = 0; m_fepc = 0; m_fepsw = 0; m_ecr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        chk(redirect_valid == 0 && halt_release == 0, "R1 strobes", {30'd0, redirect_valid, halt_release}, 0);

        // R2 disabled after reset: refused
        step(0,0,0,0,1, 4'd5, 5'd0, 32'h0000_2000, 0, "R2 disabled");
        step(0,0,0,1,0, 4'd0, 5'd0, 32'h0, 0, "R8 enable");
        // R4 R5 accept level 3 -> mask 4
        step(0,0,0,0,1, 4'd3, 5'd0, 32'h0000_1234, 0, "R4 accept lvl3");
        // R11 nested trap goes to fatal pair, injection ignored (R10)
        step(1,0,0,0,0, 4'd0, 5'h13, 32'h0000_4446, 1, "R11 nested trap");
        // R7 return from fatal pair, then from normal pair
        step(0,1,0,0,0, 4'd0, 5'd0, 32'h0, 1, "R7 fatal return");
        step(0,1,0,0,0, 4'd0, 5'd0, 32'h0, 0, "R7 normal return");
        // R6 plain trap with vector bit 4 clear, then return
        step(1,0,0,0,0, 4'd0, 5'h0B, 32'h0000_8001, 0, "R6 trap");
        step(0,1,0,0,0, 4'd0, 5'd0, 32'h0, 0, "R7 return odd pc");
        // R5 saturation at level 15
        step(0,0,0,0,1, 4'd15, 5'd0, 32'h0000_0100, 0, "R5 saturate");
        step(0,1,0,0,0, 4'd0, 5'd0, 32'h0, 0, "R7 back");
        // R9 disable wins over interrupt; R8 disable
        step(0,0,1,0,1, 4'd9, 5'd0, 32'h0, 0, "R9 di over irq");
        step(0,0,1,1,0, 4'd0, 5'd0, 32'h0, 0, "R9 di over ei");
        step(0,0,0,1,0, 4'd0, 5'd0, 32'h0, 0, "R8 enable again");
        step(0,0,0,0,1, 4'd2, 5'd0, 32'h0000_0200, 0, "R4 accept lvl2");
        step(0,1,0,0,0, 4'd0, 5'd0, 32'h0, 0, "R7 back2");
        // R2 level below mask (mask is 0 after return; raise via accept then ei)
        step(0,0,0,0,1, 4'd6, 5'd0, 32'h0000_0300, 0, "R4 accept lvl6");
        step(0,0,0,1,0, 4'd0, 5'd0, 32'h0, 0, "R8 enable in handler");
        step(0,0,0,0,1, 4'd15, 5'd0, 32'h0, 0, "R2 pending bit blocks");
        step(0,1,0,0,0, 4'd0, 5'd0, 32'h0, 0, "R7 back3");

        // Random mixes checked against the model (R9 priority over all combinations)
        for (int i = 0; i < 400; i++) begin
            bit t, r, d, e, iv;
            t  = ($urandom % 8) == 0;
            r  = ($urandom % 5) == 0;
            d  = ($urandom % 6) == 0;
            e  = ($urandom % 3) == 0;
            iv = ($urandom % 2) == 0;
            step(t, r, d, e, iv, 4'($urandom), 5'($urandom), $urandom,
                 ($urandom % 4) == 0, "R9 random mix");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule